// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the synchronisation and blanking signals for one display output. Software fills a set of timing registers over a simple write/read bus and then sets an enable bit. From then on, a line-position counter and a whole-frame pixel counter drive horizontal sync, vertical sync and a data-enable strobe. The block also produces an active-window flag and a pixel output. That output carries upstream pixel data inside the active window. It substitutes a border colour in the part of the display window that lies outside the active window. It substitutes an underflow colour whenever the upstream stream has no valid pixel in active time.

Vertical boundaries are written as absolute pixel-clock positions inside the frame, not as line counts, so the programmer folds the line length and a horizontal skew into them. The skew register also moves the start of the hsync pulse within each line. A fetch-start strobe fires once per frame at a programmable frame position. Frame and line counters can be read back while the engine runs. Every timing register is double-buffered, and the working copy changes only at a frame boundary or while the engine is off.

Top module: `disp_timing_top`

## Requirements
- R1: The line counter runs from 0 to line_len-1, where line_len is LINE_CTL (address 2) bits 31:16. hsync is asserted for LINE_CTL bits 15:0 clocks, starting at the line position equal to SKEW (address 13) and wrapping modulo line_len.
- R2: vsync is asserted while the frame position is below VS_LEN (address 4). The frame position counts from 0 to FRAME_LEN-1 (address 3), both in pixel clocks.
- R3: Data-enable is high when the frame position lies in [DV_START, DV_END] (addresses 5, 6) and the line position lies in [start, end] of DH_CTL (address 7, end in bits 31:16, start in bits 15:0).
- R4: MODE (address 1) bit 29 limits the active window horizontally to AH_CTL (address 8, same packing as DH_CTL), and bit 30 limits it vertically to [AV_START, AV_END] (addresses 9, 10). active_o is high only inside both the display window and every enabled limit. Display pixels outside the active window output BORDER (address 11).
- R5: Inside the active window the output pixel is pix_in when pix_valid is high, and UNDERFLOW (address 12) otherwise. Outside the display window the pixel output is 0.
- R6: POLARITY (address 14) bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data-enable.
- R7: ENGINE (address 0) bit 0 starts the engine. Outputs are registered: the output state after the k-th clock edge following the enabling write reflects frame position k-1.
- R8: While the engine is off, all counters are zero, the read-back counts return 0, and hsync, vsync and data-enable sit at their polarity bits with the pixel, active and fetch outputs at 0.
- R9: When MODE bit 31 is set, fetch_start_o pulses for one clock at frame position FETCH_AT (address 16); otherwise it stays low.
- R10: COUNT_EN (address 15) bit 0 lets the frame counter advance at each frame wrap, and bit 1 lets the line counter advance at each line wrap. The line counter clears at every frame wrap. Reads of address 17 (frames) and 18 (lines) return the counter value one clock later.
- R11: Register writes made while the engine runs take effect only from the next frame start (frame position wrapping to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_in | input | 24 | Upstream pixel |
| pix_valid | input | 1 | Upstream pixel valid |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| active_o | output | 1 | Inside active window |
| pix_o | output | 24 | Output pixel |
| fetch_start_o | output | 1 | Fetch-start strobe |

## Verification
The hardest case to reach is a reprogramming made in the middle of a running frame. The old timing has to stay in force until the wrap, and the new skew, polarity, window and count enables have to apply from the first pixel of the following frame. The bench writes a second configuration while frame 2 is in progress. It then sweeps every clock of five frames against an arithmetic model that picks the configuration by frame index. It alternates counter reads on the same bus on every free cycle, which exposes frame counts frozen by the changed count enable.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
  localparam int H_W     = 16;
  localparam int V_W     = 32;
  localparam int COLOR_W = 24;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] RA_ENGINE   = 5'd0;
  localparam logic [ADDR_W-1:0] RA_MODE     = 5'd1;
  localparam logic [ADDR_W-1:0] RA_LINE     = 5'd2;
  localparam logic [ADDR_W-1:0] RA_FRAME    = 5'd3;
  localparam logic [ADDR_W-1:0] RA_VS_LEN   = 5'd4;
  localparam logic [ADDR_W-1:0] RA_DV_START = 5'd5;
  localparam logic [ADDR_W-1:0] RA_DV_END   = 5'd6;
  localparam logic [ADDR_W-1:0] RA_DH_CTL   = 5'd7;
  localparam logic [ADDR_W-1:0] RA_AH_CTL   = 5'd8;
  localparam logic [ADDR_W-1:0] RA_AV_START = 5'd9;
  localparam logic [ADDR_W-1:0] RA_AV_END   = 5'd10;
  localparam logic [ADDR_W-1:0] RA_BORDER   = 5'd11;
  localparam logic [ADDR_W-1:0] RA_UFLOW    = 5'd12;
  localparam logic [ADDR_W-1:0] RA_SKEW     = 5'd13;
  localparam logic [ADDR_W-1:0] RA_POL      = 5'd14;
  localparam logic [ADDR_W-1:0] RA_CNT_EN   = 5'd15;
  localparam logic [ADDR_W-1:0] RA_FETCH    = 5'd16;
  localparam logic [ADDR_W-1:0] RA_RD_FRM   = 5'd17;
  localparam logic [ADDR_W-1:0] RA_RD_LINE  = 5'd18;

  typedef struct packed {
    logic [H_W-1:0]     line_len;
    logic [H_W-1:0]     hs_width;
    logic [H_W-1:0]     skew;
    logic [H_W-1:0]     dh_start;
    logic [H_W-1:0]     dh_end;
    logic [H_W-1:0]     ah_start;
    logic [H_W-1:0]     ah_end;
    logic [V_W-1:0]     frame_len;
    logic [V_W-1:0]     vs_len;
    logic [V_W-1:0]     dv_start;
    logic [V_W-1:0]     dv_end;
    logic [V_W-1:0]     av_start;
    logic [V_W-1:0]     av_end;
    logic [V_W-1:0]     fetch_at;
    logic [COLOR_W-1:0] border;
    logic [COLOR_W-1:0] underflow;
    logic               act_h_en;
    logic               act_v_en;
    logic               fetch_en;
    logic [2:0]         pol;
    logic [1:0]         cnt_en;
  } tcfg_t;
endpackage

// File: rtl/disp_timing_regs.sv
module disp_timing_regs
  import disp_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_wrap,
  output logic              en_o,
  output tcfg_t             cfg_o
);
  tcfg_t pend_q;
  tcfg_t cfg_q;
  logic  en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        RA_ENGINE:   en_q <= wdata[0];
        RA_MODE: begin
          pend_q.act_h_en <= wdata[29];
          pend_q.act_v_en <= wdata[30];
          pend_q.fetch_en <= wdata[31];
        end
        RA_LINE: begin
          pend_q.line_len <= wdata[31:16];
          pend_q.hs_width <= wdata[15:0];
        end
        RA_FRAME:    pend_q.frame_len <= wdata;
        RA_VS_LEN:   pend_q.vs_len    <= wdata;
        RA_DV_START: pend_q.dv_start  <= wdata;
        RA_DV_END:   pend_q.dv_end    <= wdata;
        RA_DH_CTL: begin
          pend_q.dh_end   <= wdata[31:16];
          pend_q.dh_start <= wdata[15:0];
        end
        RA_AH_CTL: begin
          pend_q.ah_end   <= wdata[31:16];
          pend_q.ah_start <= wdata[15:0];
        end
        RA_AV_START: pend_q.av_start  <= wdata;
        RA_AV_END:   pend_q.av_end    <= wdata;
        RA_BORDER:   pend_q.border    <= wdata[COLOR_W-1:0];
        RA_UFLOW:    pend_q.underflow <= wdata[COLOR_W-1:0];
        RA_SKEW:     pend_q.skew      <= wdata[H_W-1:0];
        RA_POL:      pend_q.pol       <= wdata[2:0];
        RA_CNT_EN:   pend_q.cnt_en    <= wdata[1:0];
        RA_FETCH:    pend_q.fetch_at  <= wdata;
        default: ;
      endcase
    end
  end

  // Working copy follows the pending set only while idle or at a frame wrap
  always_ff @(posedge clk) begin
    if (rst)                      cfg_q <= '0;
    else if (!en_q || frame_wrap) cfg_q <= pend_q;
  end

  assign en_o  = en_q;
  assign cfg_o = cfg_q;

  // R11: mid-frame the working configuration never moves
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (en_q && !frame_wrap) |=> $stable(cfg_q));
endmodule

// File: rtl/disp_timing_counters.sv
module disp_timing_counters
  import disp_timing_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [H_W-1:0] line_len,
  input  logic [V_W-1:0] frame_len,
  input  logic [1:0]     cnt_en,
  output logic [H_W-1:0] hpos_o,
  output logic [V_W-1:0] fpos_o,
  output logic           frame_wrap_o,
  output logic [V_W-1:0] frames_o,
  output logic [V_W-1:0] lines_o
);
  logic [H_W-1:0] h_q;
  logic [V_W-1:0] f_q, frm_q, lin_q;
  logic line_end, frame_end;

  assign line_end  = en && (h_q == line_len - 1'b1);
  assign frame_end = en && (f_q == frame_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      h_q   <= '0;
      f_q   <= '0;
      frm_q <= '0;
      lin_q <= '0;
    end else begin
      f_q <= frame_end ? '0 : f_q + 1'b1;
      h_q <= (frame_end || line_end) ? '0 : h_q + 1'b1;
      if (frame_end && cnt_en[0]) frm_q <= frm_q + 1'b1;
      if (frame_end)                    lin_q <= '0;
      else if (line_end && cnt_en[1])   lin_q <= lin_q + 1'b1;
    end
  end

  assign hpos_o       = h_q;
  assign fpos_o       = f_q;
  assign frame_wrap_o = frame_end;
  assign frames_o     = frm_q;
  assign lines_o      = lin_q;

  // R1: line position stays below the programmed line length
  a_r1_hpos_range: assert property (@(posedge clk) disable iff (rst)
    (en && line_len != '0) |-> (h_q < line_len));
  // R8: a stopped engine holds every count at zero
  a_r8_counts_clear: assert property (@(posedge clk) disable iff (rst)
    !en |=> (frm_q == '0 && lin_q == '0 && f_q == '0));
endmodule

// File: rtl/disp_timing_out.sv
module disp_timing_out
  import disp_timing_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  tcfg_t              cfg,
  input  logic [H_W-1:0]     hpos,
  input  logic [V_W-1:0]     fpos,
  input  logic [COLOR_W-1:0] pix_in,
  input  logic               pix_valid,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               active_o,
  output logic [COLOR_W-1:0] pix_o,
  output logic               fetch_o
);
  logic [H_W-1:0] hs_pos;
  logic hs_raw, vs_raw, disp_raw, win_h_ok, win_v_ok, act_raw, fetch_raw;
  logic [COLOR_W-1:0] pix_nxt;
  logic de_raw_q;

  always_comb begin
    hs_pos    = (hpos >= cfg.skew) ? hpos - cfg.skew : hpos + cfg.line_len - cfg.skew;
    hs_raw    = hs_pos < cfg.hs_width;
    vs_raw    = fpos < cfg.vs_len;
    disp_raw  = (fpos >= cfg.dv_start) && (fpos <= cfg.dv_end) &&
                (hpos >= cfg.dh_start) && (hpos <= cfg.dh_end);
    win_h_ok  = !cfg.act_h_en || ((hpos >= cfg.ah_start) && (hpos <= cfg.ah_end));
    win_v_ok  = !cfg.act_v_en || ((fpos >= cfg.av_start) && (fpos <= cfg.av_end));
    act_raw   = disp_raw && win_h_ok && win_v_ok;
    fetch_raw = cfg.fetch_en && (fpos == cfg.fetch_at);
    if (!disp_raw)      pix_nxt = '0;
    else if (!act_raw)  pix_nxt = cfg.border;
    else if (pix_valid) pix_nxt = pix_in;
    else                pix_nxt = cfg.underflow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
      de_o     <= 1'b0;
      de_raw_q <= 1'b0;
      active_o <= 1'b0;
      pix_o    <= '0;
      fetch_o  <= 1'b0;
    end else if (!en) begin
      hsync_o  <= cfg.pol[0];
      vsync_o  <= cfg.pol[1];
      de_o     <= cfg.pol[2];
      de_raw_q <= 1'b0;
      active_o <= 1'b0;
      pix_o    <= '0;
      fetch_o  <= 1'b0;
    end else begin
      hsync_o  <= hs_raw ^ cfg.pol[0];
      vsync_o  <= vs_raw ^ cfg.pol[1];
      de_o     <= disp_raw ^ cfg.pol[2];
      de_raw_q <= disp_raw;
      active_o <= act_raw;
      pix_o    <= pix_nxt;
      fetch_o  <= fetch_raw;
    end
  end

  // R8: stopped engine drives idle levels set by polarity
  a_r8_idle_levels: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hsync_o == $past(cfg.pol[0]) && vsync_o == $past(cfg.pol[1]) &&
             de_o == $past(cfg.pol[2]) && !active_o && !fetch_o));
  // R4: active window lies inside the display window
  a_r4_active_in_display: assert property (@(posedge clk) disable iff (rst)
    active_o |-> de_raw_q);
  // R5: blank pixels outside the display window
  a_r5_blank_pixel: assert property (@(posedge clk) disable iff (rst)
    !de_raw_q |-> (pix_o == '0));
  // R9: strobe only with fetch enabled
  a_r9_fetch_gated: assert property (@(posedge clk) disable iff (rst)
    fetch_o |-> $past(cfg.fetch_en));
endmodule

// File: rtl/disp_timing_top.sv
module disp_timing_top
  import disp_timing_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [COLOR_W-1:0] pix_in,
  input  logic               pix_valid,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               active_o,
  output logic [COLOR_W-1:0] pix_o,
  output logic               fetch_start_o
);
  tcfg_t          cfg;
  logic           en, frame_wrap;
  logic [H_W-1:0] hpos;
  logic [V_W-1:0] fpos, frames, lines;

  disp_timing_regs regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .frame_wrap(frame_wrap), .en_o(en), .cfg_o(cfg)
  );

  disp_timing_counters cnt_i (
    .clk(clk), .rst(rst), .en(en), .line_len(cfg.line_len),
    .frame_len(cfg.frame_len), .cnt_en(cfg.cnt_en), .hpos_o(hpos), .fpos_o(fpos),
    .frame_wrap_o(frame_wrap), .frames_o(frames), .lines_o(lines)
  );

  disp_timing_out out_i (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg), .hpos(hpos), .fpos(fpos),
    .pix_in(pix_in), .pix_valid(pix_valid), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .active_o(active_o), .pix_o(pix_o), .fetch_o(fetch_start_o)
  );

  // R10: registered counter read-back
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        RA_RD_FRM:  bus_rdata <= frames;
        RA_RD_LINE: bus_rdata <= lines;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/disp_timing_top_tb_top.sv
module disp_timing_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] pix_in = '0;
  logic        pix_valid = 1'b0;
  logic        hsync_o, vsync_o, de_o, active_o, fetch_start_o;
  logic [23:0] pix_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam int LL = 12, FL = 84, BORDER = 'h00AA55, UFLOW = 'hFF0000;

  always #2.5 clk = ~clk;

  disp_timing_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_in(pix_in),
    .pix_valid(pix_valid), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .active_o(active_o), .pix_o(pix_o), .fetch_start_o(fetch_start_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // configuration-B writes issued in the middle of frame 2
  function automatic logic [36:0] cfg_b_write(int i);
    case (i)
      0: return {5'd13, 32'd3};
      1: return {5'd14, 32'd7};
      2: return {5'd1,  32'd0};
      3: return {5'd4,  32'd24};
      4: return {5'd5,  32'd27};
      5: return {5'd6,  32'd74};
      default: return {5'd15, 32'd2};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    bus_addr = 5'd17;
    @(posedge clk); #1;
    // R8: idle after reset
    chk("R8 reset hsync", hsync_o, 0);
    chk("R8 reset vsync", vsync_o, 0);
    chk("R8 reset de", de_o, 0);
    chk("R8 reset pix", pix_o, 0);
    chk("R8 reset rdata", bus_rdata, 0);

    // configuration A
    wr(5'd2,  {16'd12, 16'd2});
    wr(5'd3,  32'd84);
    wr(5'd4,  32'd12);
    wr(5'd5,  32'd24);
    wr(5'd6,  32'd71);
    wr(5'd7,  {16'd9, 16'd4});
    wr(5'd8,  {16'd8, 16'd5});
    wr(5'd9,  32'd36);
    wr(5'd10, 32'd59);
    wr(5'd11, BORDER);
    wr(5'd12, UFLOW);
    wr(5'd13, 32'd0);
    wr(5'd14, 32'd0);
    wr(5'd15, 32'd3);
    wr(5'd16, 32'd80);
    wr(5'd1,  32'hE000_0000);
    wr(5'd0,  32'd1);   // R7: engine start

    for (int k = 1; k <= 5 * FL; k++) begin
      int  f, m, h, hp, sk, vsl, dvs, dve, pol, wi, efr, eln;
      bit  b, hs, vs, disp, act, fe, wcyc, valid;
      int  data, epix;
      valid = (k % 5) != 3;
      data  = (k * 37) & 'hFFFFFF;
      pix_in = data[23:0];
      pix_valid = valid;
      wi = k - (2 * FL + 10);
      wcyc = (wi >= 0) && (wi < 7);
      if (wcyc) begin
        logic [36:0] w;
        w = cfg_b_write(wi);
        bus_wr = 1'b1; bus_addr = w[36:32]; bus_wdata = w[31:0];
      end else begin
        bus_wr = 1'b0; bus_addr = (k % 2) ? 5'd17 : 5'd18;
      end
      @(posedge clk); #1;
      f = (k - 1) % FL;
      m = (k - 1) / FL;
      b = (m >= 3);
      h = f % LL;
      sk  = b ? 3 : 0;
      pol = b ? 7 : 0;
      vsl = b ? 24 : 12;
      dvs = b ? 27 : 24;
      dve = b ? 74 : 71;
      hp = (h >= sk) ? h - sk : h + LL - sk;
      hs = hp < 2;
      vs = f < vsl;
      disp = (f >= dvs) && (f <= dve) && (h >= 4) && (h <= 9);
      act = disp && (b || ((h >= 5) && (h <= 8) && (f >= 36) && (f <= 59)));
      fe = !b && (f == 80);
      epix = !disp ? 0 : (!act ? BORDER : (valid ? data : UFLOW));
      chk(b ? "R6 hsync" : "R1 hsync", hsync_o, hs ^ pol[0]);
      chk(k == 1 ? "R7 vsync" : (b ? "R11 vsync" : "R2 vsync"), vsync_o, vs ^ pol[1]);
      chk(b ? "R6 de" : "R3 de", de_o, disp ^ pol[2]);
      chk("R4 active", active_o, act);
      chk("R5 pixel", pix_o, epix);
      chk("R9 fetch", fetch_start_o, fe);
      if (!wcyc) begin
        efr = 0;
        for (int q = 0; q < 3; q++) if ((q + 1) * FL <= k - 1) efr++;
        eln = ((k - 1) % FL) / LL;
        if (k % 2) chk("R10 frame count", bus_rdata, efr);
        else       chk("R10 line count", bus_rdata, eln);
      end
    end

    bus_wr = 1'b0;
    wr(5'd0, 32'd0);
    bus_addr = 5'd17;
    repeat (2) @(posedge clk); #1;
    chk("R8 off hsync", hsync_o, 1);
    chk("R8 off vsync", vsync_o, 1);
    chk("R8 off de", de_o, 1);
    chk("R8 off active", active_o, 0);
    chk("R8 off pix", pix_o, 0);
    chk("R8 off frames", bus_rdata, 0);
    bus_addr = 5'd18;
    @(posedge clk); #1;
    chk("R8 off lines", bus_rdata, 0);
    summary();
  end
endmodule